// File: doc/BRIEF.md
# Mask-Directed Bit Grouping Unit

This block takes a data word and a mask of the same width and returns the data bits split into two groups. Bits whose mask bit is 0 come out first, at the most significant end. Bits whose mask bit is 1 follow them. Inside each group the bits keep the order they had in the input. Position 0 is the most significant bit. A chain of these operations, each with its own mask, can reach any arrangement of the word's bits in at most log2(width) passes.

A request is accepted on a valid/ready handshake. The grouped word appears on a registered result port one clock later, together with a valid flag and the boundary index, which is the number of bits in the first group. The network is built as log2(width) merge levels. Level k joins pairs of neighbouring blocks of 2^k bits, each already grouped, into one grouped block twice as large.

Top module: `bitGroupUnit`

## Requirements
- R1: Every data bit whose mask bit is 0 appears in the result, packed from the most significant end (position 0 = bit WIDTH-1), in the same relative order as in the input.
- R2: Every data bit whose mask bit is 1 appears directly after the first group and fills the result to the least significant end, in its original relative order.
- R3: `resBoundary` equals the number of 0 bits in the accepted mask.
- R4: `resValid` is high in exactly the cycle after a request is accepted (`reqValid && reqReady`), and low otherwise.
- R5: When no request is accepted, `resData` and `resBoundary` keep their previous values.
- R6: An all-0 mask or an all-1 mask returns the data word unchanged.
- R7: While `rst` is high, and in the first cycle after it falls, `resValid`, `resData` and `resBoundary` are 0. `reqReady` is low during reset and high from the first clock after reset.
- R8: The result holds the same number of 1 bits as the accepted data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can take a request |
| reqData | input | WIDTH | Word to be regrouped |
| reqCtrl | input | WIDTH | Group select per bit, 0 = first group |
| resValid | output | 1 | Result registers hold a new result |
| resData | output | WIDTH | Grouped word |
| resBoundary | output | $clog2(WIDTH)+1 | Size of the first group |

## Verification
An 8-bit instance is swept over all 256 masks against many data words. This covers the edge where a half-block is entirely 0s or entirely 1s. A merge level that gets the offsets wrong in that case drops or duplicates bits, and only at that one level. The worked mask 10011010 is checked by hand, because an error in bit-position order turns the result into its mirror image. On the 64-bit instance, alternating masks, walking single-bit masks and random masks push the boundary to every extreme: 0, WIDTH and one off each. An off-by-one in the boundary count shows up there. Idle cycles between requests are checked for a stray valid and for result registers that change when no request was taken.

// File: rtl/grp_pkg.sv
package grp_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;   // latch the network output into the result registers
  } grpStrobes_t;

endpackage

// File: rtl/grpMergeStage.sv
// One merge level: joins neighbouring grouped blocks of HALF bits into
// grouped blocks of 2*HALF bits. Vectors are position indexed (index 0 is
// the leftmost position).
module grpMergeStage #(
  parameter int WIDTH = 64,
  parameter int LEVEL = 0
) (
  input  logic [WIDTH-1:0] inPos,
  input  logic [WIDTH-1:0] ctrlPos,
  output logic [WIDTH-1:0] outPos
);
  localparam int HALF = 1 << LEVEL;
  localparam int BLK  = 2 * HALF;
  localparam int NBLK = WIDTH / BLK;
  localparam int IW   = $clog2(WIDTH);

  always_comb begin
    int zl;
    int zr;
    int src;
    outPos = '0;
    zl = 0;
    zr = 0;
    src = 0;
    for (int b = 0; b < NBLK; b++) begin
      // Zero counts are unchanged by the reordering inside each half-block.
      zl = 0;
      zr = 0;
      for (int k = 0; k < HALF; k++) begin
        zl = zl + int'(!ctrlPos[b*BLK + k]);
        zr = zr + int'(!ctrlPos[b*BLK + HALF + k]);
      end
      for (int p = 0; p < BLK; p++) begin
        if (p < zl)             src = p;               // left zeros
        else if (p < zl + zr)   src = HALF + p - zl;   // right zeros
        else if (p < HALF + zr) src = p - zr;          // left ones
        else                    src = p;               // right ones
        outPos[b*BLK + p] = inPos[IW'(b*BLK + src)];
      end
    end
  end

endmodule

// File: rtl/grpDatapath.sv
module grpDatapath
  import grp_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  grpStrobes_t                strobes,
  input  logic [WIDTH-1:0]           reqData,
  input  logic [WIDTH-1:0]           reqCtrl,
  output logic [WIDTH-1:0]           resData,
  output logic [$clog2(WIDTH):0]     resBoundary
);
  localparam int LG = $clog2(WIDTH);
  localparam int CW = LG + 1;

  logic [WIDTH-1:0] ctrlPos;
  logic [WIDTH-1:0] chain [LG+1];
  logic [WIDTH-1:0] netOut;
  logic [CW-1:0]    zeroCount;

  // Position p lives in bit WIDTH-1-p of the port words.
  always_comb begin
    for (int p = 0; p < WIDTH; p++) begin
      chain[0][p] = reqData[WIDTH-1-p];
      ctrlPos[p]  = reqCtrl[WIDTH-1-p];
    end
  end

  generate
    for (genvar s = 0; s < LG; s++) begin : gLevel
      grpMergeStage #(.WIDTH(WIDTH), .LEVEL(s)) uStage (
        .inPos  (chain[s]),
        .ctrlPos(ctrlPos),
        .outPos (chain[s+1])
      );
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < WIDTH; p++) netOut[WIDTH-1-p] = chain[LG][p];
  end

  assign zeroCount = CW'(WIDTH - $countones(reqCtrl));

  always_ff @(posedge clk) begin
    if (rst) begin
      resData     <= '0;
      resBoundary <= '0;
    end else if (strobes.capture) begin
      resData     <= netOut;
      resBoundary <= zeroCount;
    end
  end

  // R8: grouping moves bits, it never creates or drops a 1.
  a_r8_ones_kept: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> $countones(resData) == $countones($past(reqData)));

  // R6: a mask with no 1s leaves the word as it was.
  a_r6_zero_mask_identity: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && reqCtrl == '0) |=> resData == $past(reqData));

  // R6: a mask with no 0s also leaves the word as it was.
  a_r6_one_mask_identity: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && reqCtrl == '1) |=> resData == $past(reqData));

  // R5: result registers move only on a capture.
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(resData) && $stable(resBoundary)));

endmodule

// File: rtl/grpControl.sv
module grpControl
  import grp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        resValid,
  output grpStrobes_t strobes
);
  logic readyQ;

  assign reqReady        = readyQ;
  assign strobes.capture = reqValid && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ   <= 1'b0;
      resValid <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      resValid <= strobes.capture;
    end
  end

  // R4: an accepted request yields a valid result on the next cycle.
  a_r4_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> resValid);

  // R4: no valid without an accepted request the cycle before.
  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && reqReady) |=> !resValid);

  // R7: once out of reset, the unit keeps accepting.
  a_r7_ready_stays: assert property (@(posedge clk) disable iff (rst)
    reqReady |=> reqReady);

endmodule

// File: rtl/bitGroupUnit.sv
module bitGroupUnit
  import grp_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [WIDTH-1:0]       reqData,
  input  logic [WIDTH-1:0]       reqCtrl,
  output logic                   resValid,
  output logic [WIDTH-1:0]       resData,
  output logic [$clog2(WIDTH):0] resBoundary
);
  grpStrobes_t strobes;

  initial begin
    a_width_pow2: assert ((1 << $clog2(WIDTH)) == WIDTH);
  end

  grpControl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .resValid(resValid),
    .strobes (strobes)
  );

  grpDatapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .reqData    (reqData),
    .reqCtrl    (reqCtrl),
    .resData    (resData),
    .resBoundary(resBoundary)
  );

  // R3: the boundary never exceeds the word width.
  a_r3_boundary_range: assert property (@(posedge clk) disable iff (rst)
    resValid |-> resBoundary <= WIDTH);

endmodule

// File: tb/bitGroupUnit_test.sv
module bitGroupUnit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  int nCompared = 0;
  int nMismatch = 0;
  bit finished  = 1'b0;

  // 64-bit instance
  logic        vA, rdyA, rvA;
  logic [63:0] dA, cA, rA;
  logic [6:0]  bA;
  // 8-bit instance
  logic        vB, rdyB, rvB;
  logic [7:0]  dB, cB, rB;
  logic [3:0]  bB;

  bitGroupUnit #(.WIDTH(64)) uut (
    .clk(clk), .rst(rst), .reqValid(vA), .reqReady(rdyA), .reqData(dA),
    .reqCtrl(cA), .resValid(rvA), .resData(rA), .resBoundary(bA));

  bitGroupUnit #(.WIDTH(8)) uutSmall (
    .clk(clk), .rst(rst), .reqValid(vB), .reqReady(rdyB), .reqData(dB),
    .reqCtrl(cB), .resValid(rvB), .resData(rB), .resBoundary(bB));

  // Reference: scan positions left to right, 0-mask bits first, then 1-mask bits.
  function automatic void refGroup(input int w, input logic [63:0] d,
                                   input logic [63:0] c,
                                   output logic [63:0] r, output int z);
    int o;
    o = 0; r = '0; z = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < w; p++) begin
        if (int'(c[w-1-p]) == pass) begin
          r[w-1-o] = d[w-1-p];
          o++;
          if (pass == 0) z++;
        end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run64(input logic [63:0] d, input logic [63:0] c, input string req);
    logic [63:0] er;
    int ez;
    refGroup(64, d, c, er, ez);
    vA = 1'b1; dA = d; cA = c;
    @(negedge clk);
    vA = 1'b0;
    chk(rvA === 1'b1, {req, " R4 valid"}, 64'(rvA), 64'd1);
    chk(rA === er, {req, " R1/R2 data"}, rA, er);
    chk(int'(bA) == ez, {req, " R3 boundary"}, 64'(bA), 64'(ez));
  endtask

  task automatic run8(input logic [7:0] d, input logic [7:0] c, input string req);
    logic [63:0] er;
    int ez;
    refGroup(8, 64'(d), 64'(c), er, ez);
    vB = 1'b1; dB = d; cB = c;
    @(negedge clk);
    vB = 1'b0;
    chk(rB === er[7:0] && int'(bB) == ez && rvB === 1'b1, req,
        {52'(bB), rB, 3'b0, rvB}, {52'(ez), er[7:0], 4'b0001});
  endtask

  initial begin
    vA = 0; dA = '0; cA = '0;
    vB = 0; dB = '0; cB = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(rvA === 1'b0 && rA === '0 && bA === '0, "R7 reset outputs", rA, 64'd0);
    chk(rdyA === 1'b0, "R7 ready low in reset", 64'(rdyA), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rdyA === 1'b1 && rdyB === 1'b1, "R7 ready after reset", 64'(rdyA), 64'd1);
    chk(rvA === 1'b0 && rA === '0, "R7 outputs after reset", rA, 64'd0);

    // R6: identity masks
    run64(64'h0123_4567_89AB_CDEF, 64'h0, "R6 zero mask");
    chk(rA === 64'h0123_4567_89AB_CDEF, "R6 zero mask identity", rA, 64'h0123_4567_89AB_CDEF);
    run64(64'hFEDC_BA98_7654_3210, '1, "R6 one mask");
    chk(rA === 64'hFEDC_BA98_7654_3210, "R6 one mask identity", rA, 64'hFEDC_BA98_7654_3210);

    // R5/R4: idle cycle keeps results and drops valid
    begin
      logic [63:0] held;
      held = rA;
      dA = 64'hDEAD_BEEF_0000_FFFF; cA = 64'h5555;
      @(negedge clk);
      chk(rvA === 1'b0, "R4 no valid when idle", 64'(rvA), 64'd0);
      chk(rA === held, "R5 data held when idle", rA, held);
      chk(int'(bA) == 0, "R5 boundary held when idle", 64'(bA), 64'd0);
    end

    // Worked 8-bit example: mask 10011010, data 11010010 -> 10001101, boundary 4
    vB = 1'b1; dB = 8'b1101_0010; cB = 8'b1001_1010;
    @(negedge clk);
    vB = 1'b0;
    chk(rB === 8'b1000_1101, "R1 R2 worked example", 64'(rB), 64'h8D);
    chk(bB === 4'd4, "R3 worked example", 64'(bB), 64'd4);

    // Alternating, walking and random masks on 64 bits
    run64(64'hF0F0_F0F0_1234_5678, 64'hAAAA_AAAA_AAAA_AAAA, "R1 alt mask A");
    run64(64'hF0F0_F0F0_1234_5678, 64'h5555_5555_5555_5555, "R2 alt mask 5");
    run64(64'h8000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, "R1 half mask");
    for (int i = 0; i < 64; i++) begin
      run64({$urandom, $urandom}, 64'd1 << i, "R2 walking one");
      run64({$urandom, $urandom}, ~(64'd1 << i), "R1 walking zero");
    end
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      run64(d, {$urandom, $urandom}, "R1 R2 R3 random");
      chk($countones(rA) == $countones(d), "R8 ones kept", 64'($countones(rA)),
          64'($countones(d)));
    end

    // Near-exhaustive 8-bit sweep: all masks against many data words
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] d;
        case (k)
          0: d = 8'(c);
          1: d = ~8'(c);
          2: d = 8'hA5;
          3: d = 8'h0F;
          4: d = 8'h80;
          5: d = 8'h01;
          default: d = 8'($urandom);
        endcase
        run8(d, 8'(c), "R1 R2 R3 R4 sweep8");
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule